// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This controller decides, for every reference-clock cycle, which clocks of a watchdog and of a periodic real-time timer may tick. It also keeps the source-select bits for the core, the watchdog and the timer clock multiplexers. A level-sensitive stop request moves it out of run mode into one of two low-power flavours. A light ("pseudo") stop keeps the oscillator alive and lets each timer continue when its own enable bit allows. A deep ("full") stop silences everything except a watchdog that runs on the free-running auxiliary RC clock. Leaving a deep stop returns the three source selects to their wake-up defaults. Leaving a light stop leaves them untouched.

The multiplexers, the oscillator and the counters are outside the block. It drives only enables and select levels, and all of them are timed on one reference clock. The auxiliary watchdog clock can be told to halt while stopped. Its gate opens and closes through a two-stage synchronised handshake, and a busy flag reports the handshake. A debugger can freeze both timers and can ask the watchdog for its longest timeout.

The controller has four states. ST_RUN is normal operation. ST_PEND holds a light-stop request until the oscillator reports ready. ST_FSTOP is the deep stop and ST_PSTOP is the light stop. The transitions are:
- enter_pend: ST_RUN to ST_PEND
- enter_pstop: ST_RUN or ST_PEND to ST_PSTOP
- enter_fstop: ST_RUN or ST_PEND to ST_FSTOP
- wake: any stop state back to ST_RUN
- abandon: ST_PEND back to ST_RUN when the request is withdrawn

Top module: `lpclk_ctrl`

## Requirements
- R1: While reset is held and after it is released, core_sel is 1 (PLL source) and wd_sel is 2'b10. Bit 1 of wd_sel set means the auxiliary clock; when it is clear, bit 0 picks oscillator (1) or internal RC (0). tmr_sel is 0 (internal RC). wd_clk_en and tmr_clk_en are 1, and wd_force_max and aux_busy are 0.
- R2: A pulse on sel_wr in ST_RUN loads core_sel_in, wd_sel_in and tmr_sel_in at the next edge. This includes the edge at which a stop request is taken. A pulse on sel_wr in any other state has no effect.
- R3: A stop request with pstop_bit and osc_en both set enters ST_PSTOP once osc_rdy is 1. Until then the request waits in ST_PEND. The wait turns into a deep stop if pstop_bit or osc_en is cleared. Any other stop request enters ST_FSTOP. Each entry takes one edge.
- R4: In ST_FSTOP tmr_clk_en is 0 and osc_run is 0. wd_clk_en is 0 unless the watchdog uses the auxiliary clock with wd_static clear.
- R5: Leaving ST_FSTOP sets core_sel to 1, wd_sel to 2'b10 and tmr_sel to 0 at the same edge.
- R6: In ST_PSTOP osc_run equals osc_en. Leaving ST_PSTOP keeps all select bits unchanged.
- R7: In ST_PSTOP tmr_clk_en follows tmr_en. When wd_sel bit 1 is 0, wd_clk_en follows wd_en.
- R8: With the auxiliary watchdog clock selected and wd_static set, wd_clk_en falls two edges after any stop state is entered. It rises two edges after ST_RUN is re-entered. aux_busy is 1 from the state change until wd_clk_en has followed. With wd_static clear, the auxiliary watchdog clock keeps running in both stop flavours.
- R9: While dbg_active and dbg_stop are both 1, wd_clk_en and tmr_clk_en are 0 in every state. In that case wd_force_max equals dbg_max_en; otherwise wd_force_max is 0.
- R10: In ST_RUN and ST_PEND, with no debug freeze, tmr_clk_en is 1 and wd_clk_en is 1. The one exception is an auxiliary gate that is still reopening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Level: 1 asks for a stop, 0 asks to run |
| pstop_bit | input | 1 | Choose light stop when possible |
| osc_en | input | 1 | Oscillator enable bit |
| osc_rdy | input | 1 | Oscillator startup wait finished |
| wd_en | input | 1 | Watchdog may run in light stop |
| tmr_en | input | 1 | Timer may run in light stop |
| wd_static | input | 1 | Halt auxiliary watchdog clock while stopped |
| dbg_active | input | 1 | Debugger holds the core |
| dbg_stop | input | 1 | Freeze timers while debugging |
| dbg_max_en | input | 1 | Request longest watchdog timeout under freeze |
| sel_wr | input | 1 | Write strobe for the select bits |
| core_sel_in | input | 1 | New core source (1 = PLL) |
| wd_sel_in | input | 2 | New watchdog source |
| tmr_sel_in | input | 1 | New timer source (1 = oscillator) |
| core_sel | output | 1 | Registered core source select |
| wd_sel | output | 2 | Registered watchdog source select |
| tmr_sel | output | 1 | Registered timer source select |
| wd_clk_en | output | 1 | Watchdog clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| wd_force_max | output | 1 | Force the watchdog to its longest timeout |
| osc_run | output | 1 | Oscillator keep-running request |
| aux_busy | output | 1 | Auxiliary gate handshake in progress |

## Verification
Two pairs of events can fall on the same edge. A select write can arrive in the very cycle in which a stop request is taken. A deep-stop wake can coincide with a write offered while the block is still stopped. The bench drives sel_wr together with stop_req and expects the written selects to be visible during the stop. It then presents a write during the deep stop and expects the wake defaults to win. A debug freeze laid over a light stop is checked the same way: the enables must fall even though the per-timer enable bits are set.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PEND  = 2'd1,
        ST_FSTOP = 2'd2,
        ST_PSTOP = 2'd3
    } lp_state_t;

    parameter int WD_SEL_W = 2;

    localparam logic                DEF_CORE_SEL = 1'b1;
    localparam logic [WD_SEL_W-1:0] DEF_WD_SEL   = 2'b10;
    localparam logic                DEF_TMR_SEL  = 1'b0;

endpackage

// File: rtl/lpclk_mode_fsm.sv
module lpclk_mode_fsm
    import lpclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      pstop_bit,
    input  logic      osc_en,
    input  logic      osc_rdy,
    output lp_state_t state,
    output logic      stopped,
    output logic      run_like,
    output logic      full_exit,
    output logic      load_ok
);

    lp_state_t nxt;
    logic      pseudo_ok;

    assign pseudo_ok = pstop_bit && osc_en;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    if (!pseudo_ok)   nxt = ST_FSTOP;
                    else if (osc_rdy) nxt = ST_PSTOP;
                    else              nxt = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!stop_req)       nxt = ST_RUN;
                else if (!pseudo_ok) nxt = ST_FSTOP;
                else if (osc_rdy)    nxt = ST_PSTOP;
            end
            ST_FSTOP: if (!stop_req) nxt = ST_RUN;
            ST_PSTOP: if (!stop_req) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        stopped   = 1'b0;
        run_like  = 1'b0;
        full_exit = 1'b0;
        load_ok   = 1'b0;
        unique case (state)
            ST_RUN: begin
                run_like = 1'b1;
                load_ok  = 1'b1;
            end
            ST_PEND:  run_like = 1'b1;
            ST_FSTOP: begin
                stopped   = 1'b1;
                full_exit = !stop_req;
            end
            ST_PSTOP: stopped = 1'b1;
            default:  run_like = 1'b1;
        endcase
    end

endmodule

// File: rtl/lpclk_aux_gate.sv
module lpclk_aux_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_on,
    output logic gate_on,
    output logic busy
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] stage_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b1;
                    else        stage_q[0] <= want_on;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= 1'b1;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign gate_on = stage_q[LAST];
    assign busy    = (stage_q != {SYNC_STAGES{want_on}});

endmodule

// File: rtl/lpclk_sel_regs.sv
module lpclk_sel_regs
    import lpclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                restore,
    input  logic                core_in,
    input  logic [WD_SEL_W-1:0] wd_in,
    input  logic                tmr_in,
    output logic                core_q,
    output logic [WD_SEL_W-1:0] wd_q,
    output logic                tmr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= DEF_CORE_SEL;
            wd_q   <= DEF_WD_SEL;
            tmr_q  <= DEF_TMR_SEL;
        end else if (restore) begin
            core_q <= DEF_CORE_SEL;
            wd_q   <= DEF_WD_SEL;
            tmr_q  <= DEF_TMR_SEL;
        end else if (load) begin
            core_q <= core_in;
            wd_q   <= wd_in;
            tmr_q  <= tmr_in;
        end
    end

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int AUX_SYNC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                pstop_bit,
    input  logic                osc_en,
    input  logic                osc_rdy,
    input  logic                wd_en,
    input  logic                tmr_en,
    input  logic                wd_static,
    input  logic                dbg_active,
    input  logic                dbg_stop,
    input  logic                dbg_max_en,
    input  logic                sel_wr,
    input  logic                core_sel_in,
    input  logic [WD_SEL_W-1:0] wd_sel_in,
    input  logic                tmr_sel_in,
    output logic                core_sel,
    output logic [WD_SEL_W-1:0] wd_sel,
    output logic                tmr_sel,
    output logic                wd_clk_en,
    output logic                tmr_clk_en,
    output logic                wd_force_max,
    output logic                osc_run,
    output logic                aux_busy
);

    lp_state_t state;
    logic      stopped;
    logic      run_like;
    logic      full_exit;
    logic      load_ok;
    logic      aux_want;
    logic      aux_gate;
    logic      wd_aux;
    logic      freeze;

    lpclk_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req  (stop_req),
        .pstop_bit (pstop_bit),
        .osc_en    (osc_en),
        .osc_rdy   (osc_rdy),
        .state     (state),
        .stopped   (stopped),
        .run_like  (run_like),
        .full_exit (full_exit),
        .load_ok   (load_ok)
    );

    lpclk_sel_regs u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sel_wr && load_ok),
        .restore (full_exit),
        .core_in (core_sel_in),
        .wd_in   (wd_sel_in),
        .tmr_in  (tmr_sel_in),
        .core_q  (core_sel),
        .wd_q    (wd_sel),
        .tmr_q   (tmr_sel)
    );

    assign wd_aux   = wd_sel[WD_SEL_W-1];
    assign aux_want = !(stopped && wd_static && wd_aux);

    lpclk_aux_gate #(.SYNC_STAGES(AUX_SYNC)) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_on (aux_want),
        .gate_on (aux_gate),
        .busy    (aux_busy)
    );

    assign freeze = dbg_active && dbg_stop;

    always_comb begin
        wd_clk_en    = 1'b0;
        tmr_clk_en   = 1'b0;
        osc_run      = osc_en;
        wd_force_max = freeze && dbg_max_en;
        unique case (state)
            ST_RUN, ST_PEND: begin
                tmr_clk_en = 1'b1;
                wd_clk_en  = wd_aux ? aux_gate : 1'b1;
            end
            ST_FSTOP: begin
                osc_run   = 1'b0;
                wd_clk_en = wd_aux && aux_gate;
            end
            ST_PSTOP: begin
                tmr_clk_en = tmr_en;
                wd_clk_en  = wd_aux ? aux_gate : wd_en;
            end
            default: begin
                tmr_clk_en = 1'b1;
                wd_clk_en  = 1'b1;
            end
        endcase
        if (freeze) begin
            wd_clk_en  = 1'b0;
            tmr_clk_en = 1'b0;
        end
    end

endmodule

// File: rtl/lpclk_chk.sv
module lpclk_chk
    import lpclk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input lp_state_t           state,
    input logic                stop_req,
    input logic                tmr_en,
    input logic                dbg_active,
    input logic                dbg_stop,
    input logic                core_sel,
    input logic [WD_SEL_W-1:0] wd_sel,
    input logic                tmr_sel,
    input logic                wd_clk_en,
    input logic                tmr_clk_en,
    input logic                osc_run,
    input logic                aux_busy
);

    AST_FSTOP_TMR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FSTOP) |-> (!tmr_clk_en && !osc_run)); // R4

    AST_FSTOP_EXIT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FSTOP && !stop_req) |=> (core_sel && wd_sel == 2'b10 && !tmr_sel)); // R5

    AST_PSTOP_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PSTOP) |=> $stable({core_sel, wd_sel, tmr_sel})); // R6

    AST_STOPPED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND || (state == ST_FSTOP && stop_req)) |=> $stable({core_sel, wd_sel, tmr_sel})); // R2

    AST_PSTOP_TMR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PSTOP && !(dbg_active && dbg_stop)) |-> (tmr_clk_en == tmr_en)); // R7

    AST_AUX_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_busy) |=> aux_busy); // R8

    AST_FREEZE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && dbg_stop) |-> (!wd_clk_en && !tmr_clk_en)); // R9

    AST_PEND_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && !(dbg_active && dbg_stop)) |-> tmr_clk_en); // R10

endmodule

bind lpclk_ctrl lpclk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .stop_req   (stop_req),
    .tmr_en     (tmr_en),
    .dbg_active (dbg_active),
    .dbg_stop   (dbg_stop),
    .core_sel   (core_sel),
    .wd_sel     (wd_sel),
    .tmr_sel    (tmr_sel),
    .wd_clk_en  (wd_clk_en),
    .tmr_clk_en (tmr_clk_en),
    .osc_run    (osc_run),
    .aux_busy   (aux_busy)
);

// File: tb/lpclk_ctrl_bench.sv
module lpclk_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0, pstop_bit = 1'b0, osc_en = 1'b0, osc_rdy = 1'b0;
    logic       wd_en = 1'b0, tmr_en = 1'b0, wd_static = 1'b0;
    logic       dbg_active = 1'b0, dbg_stop = 1'b0, dbg_max_en = 1'b0;
    logic       sel_wr = 1'b0, core_sel_in = 1'b0, tmr_sel_in = 1'b0;
    logic [1:0] wd_sel_in = 2'b00;
    logic       core_sel, tmr_sel, wd_clk_en, tmr_clk_en, wd_force_max, osc_run, aux_busy;
    logic [1:0] wd_sel;

    always #2.5 clk = ~clk;

    lpclk_ctrl u_lpclk_ctrl (.*);

    // {core_sel, wd_sel[1], wd_sel[0], tmr_sel, wd_clk_en, tmr_clk_en, wd_force_max, osc_run, aux_busy}
    logic [8:0] obs;
    assign obs = {core_sel, wd_sel, tmr_sel, wd_clk_en, tmr_clk_en, wd_force_max, osc_run, aux_busy};

    typedef struct {
        string      req;
        logic [8:0] exp;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_obs(input string req, input logic [8:0] e);
        item_t it;
        it.req = req;
        it.exp = e;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    initial begin : monitor
        forever begin
            wait (q.size() > 0);
            #1;
            n_chk++;
            if (obs !== q[0].exp) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", q[0].req, obs, q[0].exp);
            end
            void'(q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        expect_obs("R1 in reset", 9'b110011000);
        rst_n = 1'b1;
        step(1);
        expect_obs("R1 after reset", 9'b110011000);

        // R2: write in run
        osc_en = 1'b1;
        sel_wr = 1'b1; core_sel_in = 1'b0; wd_sel_in = 2'b01; tmr_sel_in = 1'b1;
        step(1);
        sel_wr = 1'b0;
        expect_obs("R2 load in run", 9'b001111010);

        // R3: pending light stop while oscillator not ready
        pstop_bit = 1'b1; wd_en = 1'b1; tmr_en = 1'b0; stop_req = 1'b1;
        step(3);
        expect_obs("R3 R10 pending runs", 9'b001111010);
        sel_wr = 1'b1; core_sel_in = 1'b1;
        step(1);
        sel_wr = 1'b0;
        expect_obs("R2 write ignored while pending", 9'b001111010);
        osc_rdy = 1'b1;
        step(1);
        expect_obs("R3 R7 light stop entered", 9'b001110010);
        step(1);
        wake_check("R6 light exit keeps selects", 9'b001111010);

        // R4: deep stop, non-aux watchdog
        pstop_bit = 1'b0; stop_req = 1'b1;
        step(1);
        expect_obs("R4 deep stop", 9'b001100000);
        sel_wr = 1'b1; core_sel_in = 1'b0; wd_sel_in = 2'b00; tmr_sel_in = 1'b1;
        step(1);
        sel_wr = 1'b0;
        expect_obs("R2 write ignored in deep stop", 9'b001100000);
        stop_req = 1'b0;
        step(1);
        expect_obs("R5 deep exit defaults", 9'b110011010);

        // R8: auxiliary static in light stop
        pstop_bit = 1'b1; tmr_en = 1'b1; wd_static = 1'b1; stop_req = 1'b1;
        step(1);
        expect_obs("R8 gate still open, busy", 9'b110011011);
        step(1);
        expect_obs("R8 one edge in", 9'b110011011);
        step(1);
        expect_obs("R8 gate closed", 9'b110001010);
        stop_req = 1'b0;
        step(1);
        expect_obs("R8 reopening", 9'b110001011);
        step(1);
        expect_obs("R8 reopening second edge", 9'b110001011);
        step(1);
        expect_obs("R8 reopened", 9'b110011010);

        // R8/R4: auxiliary non-static keeps running in deep stop
        wd_static = 1'b0; pstop_bit = 1'b0; stop_req = 1'b1;
        step(2);
        expect_obs("R4 R8 aux runs in deep stop", 9'b110010000);
        stop_req = 1'b0;
        step(1);
        expect_obs("R5 wake", 9'b110011010);

        // R9: debug freeze in run
        dbg_active = 1'b1; dbg_stop = 1'b1; dbg_max_en = 1'b1;
        #1;
        expect_obs("R9 freeze with max timeout", 9'b110000110);
        dbg_max_en = 1'b0;
        #1;
        expect_obs("R9 freeze no max", 9'b110000010);
        dbg_stop = 1'b0; dbg_max_en = 1'b1;
        #1;
        expect_obs("R9 no freeze no force", 9'b110011010);
        dbg_active = 1'b0; dbg_max_en = 1'b0;

        // R9 over light stop with enables set
        pstop_bit = 1'b1; wd_en = 1'b1; tmr_en = 1'b1; stop_req = 1'b1;
        step(1);
        dbg_active = 1'b1; dbg_stop = 1'b1;
        #1;
        expect_obs("R9 freeze in light stop", 9'b110000010);
        dbg_active = 1'b0; dbg_stop = 1'b0;
        stop_req = 1'b0;
        step(1);

        // Coincidence: write taken on the stop-entry edge, then deep wake defaults
        pstop_bit = 1'b0; stop_req = 1'b1;
        sel_wr = 1'b1; core_sel_in = 1'b0; wd_sel_in = 2'b01; tmr_sel_in = 1'b1;
        step(1);
        sel_wr = 1'b0;
        expect_obs("R2 write on stop edge", 9'b001100000);
        stop_req = 1'b0;
        sel_wr = 1'b1; core_sel_in = 1'b0;
        step(1);
        sel_wr = 1'b0;
        expect_obs("R5 defaults beat write at wake", 9'b110011010);

        // R3: pending turns into deep stop when pstop bit dropped
        osc_rdy = 1'b0; pstop_bit = 1'b1; stop_req = 1'b1;
        step(2);
        expect_obs("R3 pending", 9'b110011010);
        pstop_bit = 1'b0;
        step(1);
        expect_obs("R3 pending to deep stop", 9'b110010000);
        stop_req = 1'b0;
        step(1);
        expect_obs("R5 final wake", 9'b110011010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic wake_check(input string req, input logic [8:0] e);
        stop_req = 1'b0;
        step(1);
        expect_obs(req, e);
    endtask

endmodule